// File: doc/BRIEF.md
# Low-Power Counter Register Bank with Acknowledged Reload and Compare Writes

This block is the software-facing register bank of a low-power event counter. A simple single-cycle bus port reads and writes a handful of 32-bit registers; the block turns those accesses into the static configuration, the enable level and the run level of a counter core, and it hands reload and compare values to that core. The core's own register file runs on a slower clock. The crossing into that clock is modelled as a fixed latency of `XFER_LAT` cycles.

The counter must be enabled before it accepts a reload or a compare value. Each accepted value travels through its own transfer engine. When the value arrives, the engine raises a per-channel "value landed" flag. Software polls that flag and then clears it by writing a one to the matching bit of the clear register. The configuration word is frozen while the counter is enabled. A start request only has an effect on an enabled counter, and it leaves the counter running continuously until the enable bit is dropped.

Control state machine (`lpcnt_ctl_fsm`):
- States: `CTL_OFF`, `CTL_ARMED` and `CTL_RUN`.
- `OFF->ARMED`: a control write with the enable bit set.
- `ARMED->RUN`: a control write with both the enable bit and the start bit set.
- `ARMED->OFF` and `RUN->OFF`: a control write with the enable bit clear.
- Every other control write leaves the state unchanged.

Transfer state machine (`lpcnt_xfer`, one per channel):
- States: `XF_IDLE` and `XF_SYNC`.
- `IDLE->SYNC`: an accepted write.
- `SYNC->SYNC`: the latency counter is still counting down.
- `SYNC->IDLE`: the final cycle, in which the value is delivered and the done pulse fires.

Top module: `lpcnt_regbank`

## Requirements
- R1: After reset the control, status, compare and configuration registers read 0, the reload register reads all ones in its `DW` bits, and the counter is neither enabled nor running.
- R2: A write to control (offset 0x10) takes bit 0 as the enable and bit 1 as the start request. Start moves the counter to running only if it was already enabled before the write and the write keeps bit 0 set. Writing bit 0 as 0 stops and disables it. Reading control returns bit 0 = enabled and bit 1 = running.
- R3: The configuration register (offset 0x0C) holds these fields:
  - bit 0: encoder mode
  - bit 1: external count select
  - bits 3:2: active-edge field
  - bits 6:4: prescaler

  A write to it takes effect only while the counter is disabled. While the counter is enabled, the write is dropped.
- R4: A write to reload (0x18) or compare (0x14) while the counter is disabled is dropped. It starts no transfer, sets no flag, changes no value and gives no error.
- R5: An accepted reload or compare write becomes visible on the core output and in its read-back exactly `XFER_LAT` (3) clock edges after the write's edge. On that same edge the status register (0x00) sets bit 0 for reload or bit 1 for compare.
- R6: While a channel's transfer is pending, a further write to that channel raises `bus_err` in the same cycle and has no effect. The other channel still accepts writes.
- R7: Writing a 1 to bit 0 or bit 1 of the clear register (0x04) clears the matching status flag. If a transfer completes in the same cycle, the completion wins and the flag stays set. The clear register reads 0.
- R8: The count register (0x1C) returns `count_i` and ignores writes.
- R9: A read of any unlisted offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Error response: write to a channel whose transfer is pending |
| count_i | input | 16 | Live counter value from the core |
| cfg_encoder_o | output | 1 | Encoder mode enable |
| cfg_extcnt_o | output | 1 | External count select |
| cfg_edge_o | output | 2 | Active-edge field |
| cfg_presc_o | output | 3 | Prescaler field |
| core_enable_o | output | 1 | Counter enabled |
| core_run_o | output | 1 | Counter running continuously |
| reload_o | output | 16 | Reload value delivered to the core |
| compare_o | output | 16 | Compare value delivered to the core |

## Verification
The bench probes the edges of the transfer window.
- **Old value before the third edge, new value after it.** A status flag or read-back that changes one cycle early or late shows up as a wrong value on one side of the window.
- **Second write to a busy channel.** It must return an error and leave the first value in place. A design that overwrites the held value would deliver the second value.
- **Write to the idle channel during another's transfer.** It must be accepted. A design that shares one busy state would reject it.
- **Clear in the cycle a transfer completes.** A design that lets the clear win would lose the acknowledge.
- **Frozen configuration.** A configuration write while enabled must be dropped. A design that forgot the gate would change the configuration under a running counter.
- **Premature start.** A start request on a disabled counter must only arm it. A design that ignores this would start counting with no enable.

// File: rtl/lpcnt_pkg.sv
package lpcnt_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_STAT = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CFG  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_CTL  = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_CMP  = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_RLD  = 5'h18;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 5'h1C;

    localparam int NCH    = 2;
    localparam int CH_RLD = 0;
    localparam int CH_CMP = 1;

    typedef enum logic [1:0] {
        CTL_OFF   = 2'd0,
        CTL_ARMED = 2'd1,
        CTL_RUN   = 2'd2
    } ctl_state_e;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_SYNC = 1'b1
    } xf_state_e;

endpackage

// File: rtl/lpcnt_ctl_fsm.sv
module lpcnt_ctl_fsm
    import lpcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr_i,
    input  logic en_bit_i,
    input  logic start_bit_i,
    output logic enable_o,
    output logic run_o
);

    ctl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ctl_wr_i) begin
            if (!en_bit_i) begin
                state_d = CTL_OFF;
            end else begin
                unique case (state_q)
                    CTL_OFF:   state_d = CTL_ARMED;
                    CTL_ARMED: state_d = start_bit_i ? CTL_RUN : CTL_ARMED;
                    CTL_RUN:   state_d = CTL_RUN;
                    default:   state_d = CTL_OFF;
                endcase
            end
        end
    end

    always_comb begin
        enable_o = (state_q != CTL_OFF);
        run_o    = (state_q == CTL_RUN);
    end

endmodule

// File: rtl/lpcnt_xfer.sv
module lpcnt_xfer
    import lpcnt_pkg::*;
#(
    parameter int              DW      = 16,
    parameter int              LAT     = 3,
    parameter logic [DW-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] value_o
);

    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(LAT - 1);

    xf_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] hold_q;
    logic [DW-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: if (load_i) state_d = XF_SYNC;
            XF_SYNC: if (cnt_q == '0) state_d = XF_IDLE;
            default: state_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            hold_q  <= '0;
            value_q <= RST_VAL;
        end else begin
            if (state_q == XF_IDLE && load_i) begin
                cnt_q  <= CNT_INIT;
                hold_q <= data_i;
            end else if (state_q == XF_SYNC) begin
                if (cnt_q == '0) value_q <= hold_q;
                else             cnt_q   <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        busy_o  = (state_q == XF_SYNC);
        done_o  = (state_q == XF_SYNC) && (cnt_q == '0);
        value_o = value_q;
    end

endmodule

// File: rtl/lpcnt_regbank.sv
module lpcnt_regbank
    import lpcnt_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int DW       = 16,
    parameter int CNT_W    = 16,
    parameter int PRESC_W  = 3,
    parameter int XFER_LAT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               bus_err,
    input  logic [CNT_W-1:0]   count_i,
    output logic               cfg_encoder_o,
    output logic               cfg_extcnt_o,
    output logic [1:0]         cfg_edge_o,
    output logic [PRESC_W-1:0] cfg_presc_o,
    output logic               core_enable_o,
    output logic               core_run_o,
    output logic [DW-1:0]      reload_o,
    output logic [DW-1:0]      compare_o
);

    localparam int CFG_W = PRESC_W + 4;

    logic               wr_any;
    logic               wr_ctl, wr_cfg, wr_clr;
    logic [NCH-1:0]     ch_wr;
    logic [NCH-1:0]     ch_load;
    logic [NCH-1:0]     ch_err;
    logic [NCH-1:0]     xf_busy;
    logic [NCH-1:0]     xf_done;
    logic [NCH-1:0]     ok_q;
    logic [DW-1:0]      ch_val [NCH];
    logic [CFG_W-1:0]   cfg_q;
    logic [CFG_W-1:0]   cfg_word;

    assign wr_any        = bus_req && bus_wr;
    assign wr_ctl        = wr_any && (bus_addr == OFF_CTL);
    assign wr_cfg        = wr_any && (bus_addr == OFF_CFG);
    assign wr_clr        = wr_any && (bus_addr == OFF_CLR);
    assign ch_wr[CH_RLD] = wr_any && (bus_addr == OFF_RLD);
    assign ch_wr[CH_CMP] = wr_any && (bus_addr == OFF_CMP);

    lpcnt_ctl_fsm u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr_i    (wr_ctl),
        .en_bit_i    (bus_wdata[0]),
        .start_bit_i (bus_wdata[1]),
        .enable_o    (core_enable_o),
        .run_o       (core_run_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cfg_q <= '0;
        else if (wr_cfg && !core_enable_o) cfg_q <= bus_wdata[CFG_W-1:0];
    end

    assign cfg_word      = cfg_q;
    assign cfg_encoder_o = cfg_q[0];
    assign cfg_extcnt_o  = cfg_q[1];
    assign cfg_edge_o    = cfg_q[3:2];
    assign cfg_presc_o   = cfg_q[CFG_W-1:4];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam logic [DW-1:0] RST_VAL = (ch == CH_RLD) ? {DW{1'b1}} : '0;

        assign ch_load[ch] = ch_wr[ch] && core_enable_o && !xf_busy[ch];
        assign ch_err[ch]  = ch_wr[ch] && core_enable_o &&  xf_busy[ch];

        lpcnt_xfer #(
            .DW      (DW),
            .LAT     (XFER_LAT),
            .RST_VAL (RST_VAL)
        ) u_xfer (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (ch_load[ch]),
            .data_i  (bus_wdata[DW-1:0]),
            .busy_o  (xf_busy[ch]),
            .done_o  (xf_done[ch]),
            .value_o (ch_val[ch])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        ok_q[ch] <= 1'b0;
            else if (xf_done[ch])              ok_q[ch] <= 1'b1;
            else if (wr_clr && bus_wdata[ch])  ok_q[ch] <= 1'b0;
        end
    end

    assign reload_o  = ch_val[CH_RLD];
    assign compare_o = ch_val[CH_CMP];
    assign bus_err   = |ch_err;

    always_comb begin
        bus_rdata = '0;
        if (bus_req && !bus_wr) begin
            unique case (bus_addr)
                OFF_STAT: bus_rdata = BUS_W'(ok_q);
                OFF_CFG:  bus_rdata = BUS_W'(cfg_q);
                OFF_CTL:  bus_rdata = BUS_W'({core_run_o, core_enable_o});
                OFF_CMP:  bus_rdata = BUS_W'(ch_val[CH_CMP]);
                OFF_RLD:  bus_rdata = BUS_W'(ch_val[CH_RLD]);
                OFF_CNT:  bus_rdata = BUS_W'(count_i);
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/lpcnt_regbank_chk.sv
module lpcnt_regbank_chk
    import lpcnt_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int CFG_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              bus_err,
    input logic              core_enable,
    input logic              core_run,
    input logic [CFG_W-1:0]  cfg_word,
    input logic [NCH-1:0]    xf_busy,
    input logic [NCH-1:0]    xf_done,
    input logic [NCH-1:0]    ok_flags
);

    logic wr_rld, wr_clr0;
    assign wr_rld  = bus_req && bus_wr && (bus_addr == OFF_RLD);
    assign wr_clr0 = bus_req && bus_wr && (bus_addr == OFF_CLR) && bus_wdata[0];

    assert_run_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_run |-> core_enable);

    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_enable |=> $stable(cfg_word));

    assert_disabled_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rld && !core_enable && !xf_busy[CH_RLD]) |=> !xf_busy[CH_RLD]);

    assert_flag_after_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_flags[CH_RLD]) |-> $past(xf_busy[CH_RLD]));

    assert_pending_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rld && core_enable && xf_busy[CH_RLD]) |-> bus_err);

    assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xf_done[CH_RLD] |=> ok_flags[CH_RLD]);

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr0 && !xf_done[CH_RLD]) |=> !ok_flags[CH_RLD]);

endmodule

bind lpcnt_regbank lpcnt_regbank_chk #(
    .BUS_W (BUS_W),
    .CFG_W (CFG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_err     (bus_err),
    .core_enable (core_enable_o),
    .core_run    (core_run_o),
    .cfg_word    (cfg_word),
    .xf_busy     (xf_busy),
    .xf_done     (xf_done),
    .ok_flags    (ok_q)
);

// File: tb/lpcnt_regbank_tb.sv
module lpcnt_regbank_tb;

    localparam int PER = 10;

    localparam logic [1:0] OP_I = 2'd0;
    localparam logic [1:0] OP_W = 2'd1;
    localparam logic [1:0] OP_R = 2'd2;

    localparam logic [4:0] A_STAT = 5'h00, A_CLR = 5'h04, A_CFG = 5'h0C, A_CTL = 5'h10,
                           A_CMP = 5'h14, A_RLD = 5'h18, A_CNT = 5'h1C, A_GAP = 5'h08;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VEC [NV] = '{
        '{OP_R, A_CTL,  32'h0,    32'h0,    1'b0, 4'd1},  // R1
        '{OP_R, A_STAT, 32'h0,    32'h0,    1'b0, 4'd1},
        '{OP_R, A_RLD,  32'h0,    32'hFFFF, 1'b0, 4'd1},
        '{OP_R, A_CMP,  32'h0,    32'h0,    1'b0, 4'd1},
        '{OP_R, A_CFG,  32'h0,    32'h0,    1'b0, 4'd1},
        '{OP_W, A_RLD,  32'h0055, 32'h0,    1'b0, 4'd4},  // R4 disabled write
        '{OP_I, A_STAT, 32'h0,    32'h0,    1'b0, 4'd4},
        '{OP_I, A_STAT, 32'h0,    32'h0,    1'b0, 4'd4},
        '{OP_I, A_STAT, 32'h0,    32'h0,    1'b0, 4'd4},
        '{OP_R, A_RLD,  32'h0,    32'hFFFF, 1'b0, 4'd4},
        '{OP_R, A_STAT, 32'h0,    32'h0,    1'b0, 4'd4},
        '{OP_W, A_CFG,  32'h5B,   32'h0,    1'b0, 4'd3},  // R3
        '{OP_R, A_CFG,  32'h0,    32'h5B,   1'b0, 4'd3},
        '{OP_W, A_CTL,  32'h3,    32'h0,    1'b0, 4'd2},  // R2 start while off
        '{OP_R, A_CTL,  32'h0,    32'h1,    1'b0, 4'd2},
        '{OP_W, A_CFG,  32'h00,   32'h0,    1'b0, 4'd3},
        '{OP_R, A_CFG,  32'h0,    32'h5B,   1'b0, 4'd3},
        '{OP_W, A_CTL,  32'h3,    32'h0,    1'b0, 4'd2},
        '{OP_R, A_CTL,  32'h0,    32'h3,    1'b0, 4'd2},
        '{OP_W, A_RLD,  32'h1234, 32'h0,    1'b0, 4'd5},  // R5 accepted
        '{OP_W, A_RLD,  32'h9999, 32'h0,    1'b1, 4'd6},  // R6 pending
        '{OP_R, A_STAT, 32'h0,    32'h0,    1'b0, 4'd5},
        '{OP_R, A_RLD,  32'h0,    32'hFFFF, 1'b0, 4'd5},
        '{OP_R, A_STAT, 32'h0,    32'h1,    1'b0, 4'd5},
        '{OP_R, A_RLD,  32'h0,    32'h1234, 1'b0, 4'd6},
        '{OP_W, A_CMP,  32'h00AA, 32'h0,    1'b0, 4'd5},
        '{OP_I, A_STAT, 32'h0,    32'h0,    1'b0, 4'd5},
        '{OP_I, A_STAT, 32'h0,    32'h0,    1'b0, 4'd5},
        '{OP_I, A_STAT, 32'h0,    32'h0,    1'b0, 4'd5},
        '{OP_R, A_STAT, 32'h0,    32'h3,    1'b0, 4'd5},
        '{OP_R, A_CMP,  32'h0,    32'h00AA, 1'b0, 4'd5},
        '{OP_W, A_CLR,  32'h1,    32'h0,    1'b0, 4'd7},  // R7
        '{OP_R, A_STAT, 32'h0,    32'h2,    1'b0, 4'd7},
        '{OP_R, A_CLR,  32'h0,    32'h0,    1'b0, 4'd7},
        '{OP_W, A_CLR,  32'h2,    32'h0,    1'b0, 4'd7},
        '{OP_R, A_STAT, 32'h0,    32'h0,    1'b0, 4'd7},
        '{OP_W, A_CNT,  32'h7777, 32'h0,    1'b0, 4'd8},  // R8
        '{OP_R, A_CNT,  32'h0,    32'hBEEF, 1'b0, 4'd8},
        '{OP_R, A_GAP,  32'h0,    32'h0,    1'b0, 4'd9},  // R9
        '{OP_W, A_CTL,  32'h0,    32'h0,    1'b0, 4'd2},
        '{OP_R, A_CTL,  32'h0,    32'h0,    1'b0, 4'd2},
        '{OP_W, A_CFG,  32'h0C,   32'h0,    1'b0, 4'd3},
        '{OP_R, A_CFG,  32'h0,    32'h0C,   1'b0, 4'd3}
    };

    logic        clk, rst_n, bus_req, bus_wr, bus_err;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [15:0] count_i;
    logic        cfg_encoder_o, cfg_extcnt_o, core_enable_o, core_run_o;
    logic [1:0]  cfg_edge_o;
    logic [2:0]  cfg_presc_o;
    logic [15:0] reload_o, compare_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    lpcnt_regbank u_dut (
        .clk (clk), .rst_n (rst_n), .bus_req (bus_req), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .bus_err (bus_err), .count_i (count_i), .cfg_encoder_o (cfg_encoder_o),
        .cfg_extcnt_o (cfg_extcnt_o), .cfg_edge_o (cfg_edge_o),
        .cfg_presc_o (cfg_presc_o), .core_enable_o (core_enable_o),
        .core_run_o (core_run_o), .reload_o (reload_o), .compare_o (compare_o)
    );

    initial clk = 1'b0;
    always #(PER/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [1:0] op, input logic [4:0] a,
                             input logic [31:0] d);
        @(negedge clk);
        bus_req   = (op != OP_I);
        bus_wr    = (op == OP_W);
        bus_addr  = a;
        bus_wdata = d;
        #(PER/4);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        bus_cycle(OP_R, a, 32'h0);
        chk(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic exp_err,
                      input string req);
        bus_cycle(OP_W, a, d);
        chk(bus_err == exp_err, req, {31'h0, bus_err}, {31'h0, exp_err});
    endtask

    initial begin
        rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        count_i = 16'hBEEF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(PER/4);
        // R1 reset state at the ports
        chk(reload_o == 16'hFFFF, "R1", 32'(reload_o), 32'hFFFF);
        chk(compare_o == 16'h0, "R1", 32'(compare_o), 32'h0);
        chk({core_enable_o, core_run_o} == 2'b00, "R1", 32'({core_enable_o, core_run_o}), 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_cycle(VEC[i].op, VEC[i].addr, VEC[i].wd);
            if (VEC[i].op == OP_W)
                chk(bus_err == VEC[i].err, $sformatf("R%0d vec %0d err", VEC[i].req, i),
                    {31'h0, bus_err}, {31'h0, VEC[i].err});
            else if (VEC[i].op == OP_R)
                chk(bus_rdata == VEC[i].exp && !bus_err,
                    $sformatf("R%0d vec %0d", VEC[i].req, i), bus_rdata, VEC[i].exp);
        end
        bus_cycle(OP_I, 5'h0, 32'h0);

        // R3 config fields at the ports (0x0C written: edge=3)
        chk(cfg_edge_o == 2'd3 && cfg_presc_o == 3'd0 && !cfg_encoder_o && !cfg_extcnt_o,
            "R3", 32'({cfg_presc_o, cfg_edge_o, cfg_extcnt_o, cfg_encoder_o}), 32'h0C);
        // R5 delivered values at the ports
        chk(reload_o == 16'h1234, "R5", 32'(reload_o), 32'h1234);
        chk(compare_o == 16'h00AA, "R5", 32'(compare_o), 32'h00AA);

        // R7 completion beats a same-cycle clear; R6 other channel independent
        wr(A_CTL, 32'h1, 1'b0, "R2");
        wr(A_RLD, 32'h0F0F, 1'b0, "R5");
        wr(A_CMP, 32'h0101, 1'b0, "R6");
        bus_cycle(OP_I, 5'h0, 32'h0);
        wr(A_CLR, 32'h1, 1'b0, "R7");
        rd(A_STAT, 32'h1, "R7");
        rd(A_STAT, 32'h3, "R6");
        chk(compare_o == 16'h0101, "R6", 32'(compare_o), 32'h0101);

        // R2 run level at the ports
        wr(A_CTL, 32'h3, 1'b0, "R2");
        bus_cycle(OP_I, 5'h0, 32'h0);
        chk(core_run_o && core_enable_o, "R2", 32'({core_run_o, core_enable_o}), 32'h3);
        wr(A_CTL, 32'h2, 1'b0, "R2");
        bus_cycle(OP_I, 5'h0, 32'h0);
        chk(!core_run_o && !core_enable_o, "R2", 32'({core_run_o, core_enable_o}), 32'h0);

        // R1 reset in mid operation
        @(negedge clk);
        rst_n = 1'b0;
        #(PER/4);
        chk(reload_o == 16'hFFFF && compare_o == 16'h0, "R1", 32'({reload_o, compare_o}),
            32'hFFFF0000);
        @(negedge clk);
        rst_n = 1'b1;
        rd(A_STAT, 32'h0, "R1");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule